// File: doc/BRIEF.md
# Row Lane Sharing Network

This block moves data between the lanes of a 64-lane wavefront before the values reach an ALU. The lanes are arranged as four rows of sixteen. Within a row, lane position `p` (0 to 15) belongs to bank `p mod 4`. Each request carries one operation code, a 4-bit parameter and an 8-bit quad-select field. Every destination lane computes a source position in its own row, fetches that lane's data, and writes the result back under the control of the row and bank enables. When the source position falls outside the row, or the source lane is inactive, two policy bits decide whether the lane receives zero, keeps its previous value, or still fetches the source.

A request is presented for one cycle with `in_valid` high. It must come with the full source vector, the destination's previous contents (`old_data`) and the execution mask. The shared vector appears on `out_data` one clock later, with `out_valid` high. In wave32 mode only the first two rows take part.

Top module: `lane_share_net`

## Requirements
- R1: While reset is asserted, and after it is released with no request, `out_valid` is 0 and `out_data` is all zeros.
- R2: With opcode 0 (quad permute), the lane at position `4g+k` of a row takes the lane at position `4g+s` of the same row, where `s = qperm[2k+1:2k]`.
- R3: With opcode 1 (row mirror), position `p` takes position `15-p` of its row.
- R4: With opcode 2 (half-row mirror), position `p` takes the mirrored position inside its own group of 8, which is `p XOR 7`.
- R5: With opcode 3 (broadcast), every position of a row takes position `param` of that row.
- R6: With opcode 4 (XOR fetch), position `p` takes position `p XOR param` of its row.
- R7: With opcode 5 (shift left), position `p` takes `p+param`. With opcode 6 (shift right), it takes `p-param`. A source outside 0..15 is invalid: the lane gets zero when `bound_ctrl` is 1 and keeps `old_data` when it is 0. A parameter of 0 passes each lane its own value.
- R8: With opcode 7 (rotate right), position `p` takes `(p-param) mod 16`. The value wraps within its row.
- R9: A lane is written only when `row_mask[row]` and `bank_mask[p mod 4]` are both 1. Otherwise it outputs its `old_data`.
- R10: With `wave32` at 1, the lanes of rows 2 and 3 output their `old_data`, whatever the masks say.
- R11: A source lane whose `exec_mask` bit is 0 is inactive. With `fetch_inact` at 1 its data is still fetched. With `fetch_inact` at 0 the destination gets zero when `bound_ctrl` is 1 and keeps `old_data` when it is 0.
- R12: `out_valid` equals `in_valid` delayed by one clock. `out_data` changes only in the cycle after a request and holds otherwise.
- R13: Opcodes 8 to 15 pass each lane its own source value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| param | input | 4 | Lane, XOR value or shift amount |
| qperm | input | 8 | Four 2-bit selectors for quad permute |
| row_mask | input | 4 | Per-row write enable |
| bank_mask | input | 4 | Per-bank write enable |
| bound_ctrl | input | 1 | Invalid source returns zero (1) or keeps the old value (0) |
| fetch_inact | input | 1 | Fetch inactive sources as they are |
| wave32 | input | 1 | Restrict the operation to rows 0 and 1 |
| exec_mask | input | 64 | Active-lane mask |
| src_data | input | 2048 | Source vector, lane L at bits [32L+31:32L] |
| old_data | input | 2048 | Previous destination vector, same layout |
| out_valid | output | 1 | Result strobe |
| out_data | output | 2048 | Shared result vector, same layout |

## Verification
Each stage is combinational up to one output register, so an error in a source index, a range flag or a write enable appears on `out_data` in the very next cycle. It shows as a lane holding the wrong source, an unexpected zero, or a stale old value. The data patterns tag every source and old value with its lane number, so a miscompare shows at once which path was taken. The checks cover every opcode, both kinds of invalid source, each policy setting, and the row, bank and wave32 gating.

// File: rtl/lane_share_pkg.sv
package lane_share_pkg;

    typedef enum logic [3:0] {
        OP_QPERM   = 4'd0,
        OP_MIRROR  = 4'd1,
        OP_HMIRROR = 4'd2,
        OP_SHARE   = 4'd3,
        OP_XMASK   = 4'd4,
        OP_SHL     = 4'd5,
        OP_SHR     = 4'd6,
        OP_ROR     = 4'd7
    } share_op_e;

endpackage

// File: rtl/row_src_index.sv
module row_src_index
    import lane_share_pkg::*;
#(
    parameter int ROW_W = 16
) (
    input  logic [3:0]               op,
    input  logic [$clog2(ROW_W)-1:0] param,
    input  logic [7:0]               qperm,
    input  logic [$clog2(ROW_W)-1:0] pos,
    output logic [$clog2(ROW_W)-1:0] src,
    output logic                     in_range
);
    localparam int IDXW = $clog2(ROW_W);
    localparam logic [IDXW-1:0] FULL_FLIP = IDXW'(ROW_W - 1);
    localparam logic [IDXW-1:0] HALF_FLIP = IDXW'(ROW_W / 2 - 1);

    share_op_e       op_e;
    logic [IDXW:0]   ahead;
    logic [IDXW:0]   behind;
    logic [1:0]      quad_sel;

    assign op_e     = share_op_e'(op);
    assign ahead    = {1'b0, pos} + {1'b0, param};
    assign behind   = {1'b0, pos} - {1'b0, param};
    assign quad_sel = qperm[2*pos[1:0] +: 2];

    always_comb begin
        src      = pos;
        in_range = 1'b1;
        unique case (op_e)
            OP_QPERM:   src = {pos[IDXW-1:2], quad_sel};
            OP_MIRROR:  src = pos ^ FULL_FLIP;
            OP_HMIRROR: src = pos ^ HALF_FLIP;
            OP_SHARE:   src = param;
            OP_XMASK:   src = pos ^ param;
            OP_SHL: begin
                src      = ahead[IDXW-1:0];
                in_range = ~ahead[IDXW];
            end
            OP_SHR: begin
                src      = behind[IDXW-1:0];
                in_range = ~behind[IDXW];
            end
            OP_ROR:     src = pos - param;
            default:    src = pos;
        endcase
    end

    // R7: an in-row left shift never reads behind, a right shift never ahead
    always_comb begin
        if (op == 4'd5 && in_range)
            assert_shl_ahead_R7: assert (src >= pos);
        if (op == 4'd6 && in_range)
            assert_shr_behind_R7: assert (src <= pos);
    end

endmodule

// File: rtl/lane_pick.sv
module lane_pick #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] src_val,
    input  logic [DW-1:0] old_val,
    input  logic          src_active,
    input  logic          in_range,
    input  logic          write_en,
    input  logic          bound_ctrl,
    input  logic          fetch_inact,
    output logic [DW-1:0] res
);
    logic [DW-1:0] fallback;

    assign fallback = bound_ctrl ? '0 : old_val;

    always_comb begin
        if (!write_en)
            res = old_val;
        else if (!in_range)
            res = fallback;
        else if (!src_active && !fetch_inact)
            res = fallback;
        else
            res = src_val;
    end

endmodule

// File: rtl/lane_share_net.sv
module lane_share_net
    import lane_share_pkg::*;
#(
    parameter int DW       = 32,
    parameter int NUM_ROWS = 4,
    parameter int ROW_W    = 16,
    parameter int BANKS    = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [3:0]                     op,
    input  logic [$clog2(ROW_W)-1:0]       param,
    input  logic [7:0]                     qperm,
    input  logic [NUM_ROWS-1:0]            row_mask,
    input  logic [BANKS-1:0]               bank_mask,
    input  logic                           bound_ctrl,
    input  logic                           fetch_inact,
    input  logic                           wave32,
    input  logic [NUM_ROWS*ROW_W-1:0]      exec_mask,
    input  logic [NUM_ROWS*ROW_W*DW-1:0]   src_data,
    input  logic [NUM_ROWS*ROW_W*DW-1:0]   old_data,
    output logic                           out_valid,
    output logic [NUM_ROWS*ROW_W*DW-1:0]   out_data
);
    localparam int IDXW      = $clog2(ROW_W);
    localparam int LANES     = NUM_ROWS * ROW_W;
    localparam int LW        = $clog2(LANES);
    localparam int HALF_ROWS = NUM_ROWS / 2;
    localparam int BW        = $clog2(BANKS);

    logic [IDXW-1:0]     pos_src [ROW_W];
    logic                pos_ok  [ROW_W];
    logic [DW-1:0]       src_arr [LANES];
    logic [LANES*DW-1:0] next_data;

    for (genvar p = 0; p < ROW_W; p++) begin : g_pos
        row_src_index #(.ROW_W(ROW_W)) u_idx (
            .op       (op),
            .param    (param),
            .qperm    (qperm),
            .pos      (IDXW'(p)),
            .src      (pos_src[p]),
            .in_range (pos_ok[p])
        );
    end

    for (genvar l = 0; l < LANES; l++) begin : g_unpack
        assign src_arr[l] = src_data[l*DW +: DW];
    end

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        localparam logic LOW_ROW = (r < HALF_ROWS);
        for (genvar p = 0; p < ROW_W; p++) begin : g_lane
            localparam int L = r * ROW_W + p;
            logic [LW-1:0] src_lane;
            logic          wr_en;

            assign src_lane = LW'(r * ROW_W) | LW'(pos_src[p]);
            assign wr_en    = row_mask[r] & bank_mask[BW'(p % BANKS)]
                              & (~wave32 | LOW_ROW);

            lane_pick #(.DW(DW)) u_pick (
                .src_val     (src_arr[src_lane]),
                .old_val     (old_data[L*DW +: DW]),
                .src_active  (exec_mask[src_lane]),
                .in_range    (pos_ok[p]),
                .write_en    (wr_en),
                .bound_ctrl  (bound_ctrl),
                .fetch_inact (fetch_inact),
                .res         (next_data[L*DW +: DW])
            );
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_data <= next_data;
        end
    end

    assert_valid_follow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
    assert_row0_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !row_mask[0]) |=> out_data[DW-1:0] == $past(old_data[DW-1:0]));
    assert_wave32_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wave32) |=>
        out_data[LANES*DW-1 -: DW] == $past(old_data[LANES*DW-1 -: DW]));

endmodule

// File: tb/tb_lane_share_net.sv
`timescale 1ns/1ps
module tb_lane_share_net;
    localparam int DW    = 32;
    localparam int LANES = 64;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic [3:0]        op;
    logic [3:0]        param;
    logic [7:0]        qperm;
    logic [3:0]        row_mask;
    logic [3:0]        bank_mask;
    logic              bound_ctrl;
    logic              fetch_inact;
    logic              wave32;
    logic [LANES-1:0]  exec_mask;
    logic [LANES*DW-1:0] src_data;
    logic [LANES*DW-1:0] old_data;
    logic              out_valid;
    logic [LANES*DW-1:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    lane_share_net dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .param(param),
        .qperm(qperm), .row_mask(row_mask), .bank_mask(bank_mask),
        .bound_ctrl(bound_ctrl), .fetch_inact(fetch_inact), .wave32(wave32),
        .exec_mask(exec_mask), .src_data(src_data), .old_data(old_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    typedef struct packed {
        logic [3:0]  v_op;
        logic [3:0]  v_param;
        logic [7:0]  v_qperm;
        logic [3:0]  v_rmask;
        logic [3:0]  v_bmask;
        logic        v_bc;
        logic        v_fi;
        logic        v_w32;
        logic        v_ex;    // 1: lane 5 inactive
        logic [5:0]  v_lane;
        logic [31:0] v_exp;
        logic [3:0]  v_req;
    } vec_t;

    // source lane L = 5A0000xx, old lane L = C30000xx, xx = L
    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 4'd0, 8'h1B, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 6'd17, 32'h5A000012, 4'd2},  // R2
        '{4'd0, 4'd0, 8'h1B, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 6'd6,  32'h5A000005, 4'd2},  // R2
        '{4'd1, 4'd0, 8'h00, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 6'd19, 32'h5A00001C, 4'd3},  // R3
        '{4'd2, 4'd0, 8'h00, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 6'd9,  32'h5A00000E, 4'd4},  // R4
        '{4'd2, 4'd0, 8'h00, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 6'd34, 32'h5A000025, 4'd4},  // R4
        '{4'd3, 4'd7, 8'h00, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 6'd50, 32'h5A000037, 4'd5},  // R5
        '{4'd4, 4'd5, 8'h00, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 6'd3,  32'h5A000006, 4'd6},  // R6
        '{4'd4, 4'd5, 8'h00, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 6'd20, 32'h5A000011, 4'd6},  // R6
        '{4'd5, 4'd3, 8'h00, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 6'd2,  32'h5A000005, 4'd7},  // R7
        '{4'd5, 4'd3, 8'h00, 4'hF, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0, 6'd14, 32'h00000000, 4'd7},  // R7
        '{4'd5, 4'd3, 8'h00, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 6'd14, 32'hC300000E, 4'd7},  // R7
        '{4'd6, 4'd2, 8'h00, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 6'd17, 32'hC3000011, 4'd7},  // R7
        '{4'd6, 4'd2, 8'h00, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 6'd20, 32'h5A000012, 4'd7},  // R7
        '{4'd5, 4'd0, 8'h00, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 6'd9,  32'h5A000009, 4'd7},  // R7
        '{4'd7, 4'd4, 8'h00, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 6'd1,  32'h5A00000D, 4'd8},  // R8
        '{4'd7, 4'd4, 8'h00, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 6'd36, 32'h5A000020, 4'd8},  // R8
        '{4'd1, 4'd0, 8'h00, 4'hD, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 6'd17, 32'hC3000011, 4'd9},  // R9
        '{4'd1, 4'd0, 8'h00, 4'hD, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 6'd33, 32'h5A00002E, 4'd9},  // R9
        '{4'd1, 4'd0, 8'h00, 4'hF, 4'hE, 1'b0, 1'b0, 1'b0, 1'b0, 6'd4,  32'hC3000004, 4'd9},  // R9
        '{4'd1, 4'd0, 8'h00, 4'hF, 4'hE, 1'b0, 1'b0, 1'b0, 1'b0, 6'd5,  32'h5A00000A, 4'd9},  // R9
        '{4'd1, 4'd0, 8'h00, 4'hF, 4'hF, 1'b0, 1'b0, 1'b1, 1'b0, 6'd40, 32'hC3000028, 4'd10}, // R10
        '{4'd1, 4'd0, 8'h00, 4'hF, 4'hF, 1'b0, 1'b0, 1'b1, 1'b0, 6'd24, 32'h5A000017, 4'd10}, // R10
        '{4'd3, 4'd5, 8'h00, 4'hF, 4'hF, 1'b0, 1'b1, 1'b0, 1'b1, 6'd0,  32'h5A000005, 4'd11}, // R11
        '{4'd3, 4'd5, 8'h00, 4'hF, 4'hF, 1'b1, 1'b0, 1'b0, 1'b1, 6'd0,  32'h00000000, 4'd11}, // R11
        '{4'd3, 4'd5, 8'h00, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0, 1'b1, 6'd0,  32'hC3000000, 4'd11}, // R11
        '{4'd3, 4'd5, 8'h00, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0, 1'b1, 6'd21, 32'h5A000015, 4'd11}, // R11
        '{4'd9, 4'd0, 8'h00, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 6'd30, 32'h5A00001E, 4'd13}  // R13
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [LANES*DW-1:0] held;
        rst_n = 1'b0; in_valid = 1'b0; op = '0; param = '0; qperm = '0;
        row_mask = 4'hF; bank_mask = 4'hF; bound_ctrl = 1'b0; fetch_inact = 1'b0;
        wave32 = 1'b0; exec_mask = '1;
        for (int l = 0; l < LANES; l++) begin
            src_data[l*DW +: DW] = 32'h5A000000 + l;
            old_data[l*DW +: DW] = 32'hC3000000 + l;
        end
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", {31'd0, out_valid}, 32'd0);
        check("R1 data after reset", {31'd0, |out_data}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op = VECS[i].v_op; param = VECS[i].v_param; qperm = VECS[i].v_qperm;
            row_mask = VECS[i].v_rmask; bank_mask = VECS[i].v_bmask;
            bound_ctrl = VECS[i].v_bc; fetch_inact = VECS[i].v_fi;
            wave32 = VECS[i].v_w32;
            exec_mask = VECS[i].v_ex ? ~(64'd1 << 5) : '1;
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("R%0d vector %0d lane %0d", VECS[i].v_req, i, VECS[i].v_lane),
                  out_data[VECS[i].v_lane*DW +: DW], VECS[i].v_exp);
        end

        // R12: one-cycle result strobe, then hold while idle
        @(negedge clk);
        op = 4'd1; param = '0; row_mask = 4'hF; bank_mask = 4'hF;
        wave32 = 1'b0; exec_mask = '1; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R12 valid one cycle later", {31'd0, out_valid}, 32'd1);
        held = out_data;
        op = 4'd3; param = 4'd9;
        @(negedge clk);
        check("R12 valid drops", {31'd0, out_valid}, 32'd0);
        check("R12 data holds while idle", {31'd0, out_data == held}, 32'd1);
        check("R3 mirror lane 0", out_data[0 +: DW], 32'h5A00000F);

        finish_run();
    end

endmodule